// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the control state of a single descriptor ring that software and a DMA engine share. Software reaches it through a simple word-wide register port. Each ring owns a 32-byte window whose start is a window base plus 32 times the ring number. Inside that window, software programs a 64-bit ring base address, a ring size and the producer index (head). It can also reset the ring and keep a credit word. The hardware side moves the consumer index (tail) forward with a completion strobe.

The block enforces the ring's rules itself. Head and tail wrap modulo the ring size. A head write that would move past the tail is refused. A head value outside the ring raises a sticky fault flag. Any reprogramming of the base or the size returns both indices to zero. The block reports empty, full and the number of posted entries that the hardware has not yet completed, so that a fetch engine can be driven directly from its outputs.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset, head and tail are 0, size is 2, base address and credits are 0, fault is 0, empty is 1 and full is 0.
- R2: A register access hits only when the address lies in the window starting at WIN_BASE + 32*RING_IDX and its two low bits are 0. Word offsets are: base low +0x00, base high +0x04, size +0x08, head +0x0C, tail +0x10, control +0x14, credits +0x18, spare +0x1C. Reads outside the window, and reads of control and spare, return 0. Writes outside the window change nothing.
- R3: A size write is accepted only for a power of two from 2 to 2^MAX_LOG2. Any other value leaves the previous size in place.
- R4: Any write to base low, base high or size clears head, tail and fault on the next clock. A size write does this whether or not the size is accepted.
- R5: A control write with bit 0 set clears head, tail and fault. With bit 0 clear, a control write has no effect.
- R6: Tail cannot be written. A write to the tail offset leaves tail unchanged.
- R7: A head write of value v is accepted only if v < size and the forward move (v - head) mod size does not exceed the free slots (tail - head - 1) mod size. Otherwise head is unchanged.
- R8: A head write with v >= size sets fault. Fault stays set until an R4 or R5 clear.
- R9: Each clock with cmpl_strobe high advances tail by one modulo size while tail differs from head. When tail equals head, the strobe is ignored.
- R10: empty = (head == tail); full = ((head + 1) mod size == tail); work_avail = (head - tail) mod size.
- R11: The credits register stores the written value and reads it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| cmpl_strobe | input | 1 | Hardware completion of one descriptor |
| base_addr | output | 64 | Ring base address |
| ring_size | output | MAX_LOG2+1 | Current ring size in entries |
| head_idx | output | MAX_LOG2 | Producer index |
| tail_idx | output | MAX_LOG2 | Consumer index |
| ring_empty | output | 1 | Head equals tail |
| ring_full | output | 1 | Head one slot behind tail |
| work_avail | output | MAX_LOG2 | Posted entries not yet completed |
| fault | output | 1 | Sticky out-of-range head write flag |

## Verification
A corrupted head or tail shows on the index outputs and in work_avail on the clock after the bad update. A wrong wrap mask appears as soon as tail or head passes the last slot: the index reaches the size value or jumps back to zero too early. A faulty legality decision shows one cycle after the offending head write, either as a head value that ran past tail or as a refused legal move. A lost clear shows up as nonzero indices on the cycle after a base, size or control write.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

   localparam int unsigned WIN_BYTES      = 32;
   localparam int unsigned CTRL_RESET_BIT = 0;

   // word select inside the per-ring window (address bits [4:2])
   typedef enum logic [2:0] {
      SEL_BASE_LO = 3'd0,
      SEL_BASE_HI = 3'd1,
      SEL_SIZE    = 3'd2,
      SEL_HEAD    = 3'd3,
      SEL_TAIL    = 3'd4,
      SEL_CTRL    = 3'd5,
      SEL_CRED    = 3'd6,
      SEL_SPARE   = 3'd7
   } reg_sel_e;

   typedef struct packed {
      logic base_lo;
      logic base_hi;
      logic size;
      logic head;
      logic ctrl;
      logic cred;
   } wr_strobe_t;

endpackage

// File: rtl/ring_reg_decode.sv
module ring_reg_decode
   import ring_ptr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned WIN_BASE = 'h1000,
   parameter int unsigned RING_IDX = 2
) (
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   output logic              hit,
   output reg_sel_e          sel,
   output wr_strobe_t        wr_stb
);

   localparam int unsigned WIN_LSB   = $clog2(WIN_BYTES);
   localparam int unsigned WIN_START = WIN_BASE + WIN_BYTES * RING_IDX;
   localparam logic [ADDR_W-1:0] WIN_START_A = ADDR_W'(WIN_START);

   if ((WIN_START + WIN_BYTES) > (64'd1 << ADDR_W)) begin : g_win_range_err
      initial $fatal(1, "ring window does not fit in ADDR_W");
   end
   if ((WIN_START % WIN_BYTES) != 0) begin : g_win_align_err
      initial $fatal(1, "ring window start must be 32-byte aligned");
   end

   always_comb begin
      hit = (reg_addr[ADDR_W-1:WIN_LSB] == WIN_START_A[ADDR_W-1:WIN_LSB]) &&
            (reg_addr[1:0] == 2'b00);
      sel = reg_sel_e'(reg_addr[WIN_LSB-1:2]);
      wr_stb = '0;
      if (reg_wr && hit) begin
         unique case (sel)
            SEL_BASE_LO: wr_stb.base_lo = 1'b1;
            SEL_BASE_HI: wr_stb.base_hi = 1'b1;
            SEL_SIZE:    wr_stb.size    = 1'b1;
            SEL_HEAD:    wr_stb.head    = 1'b1;
            SEL_CTRL:    wr_stb.ctrl    = 1'b1;
            SEL_CRED:    wr_stb.cred    = 1'b1;
            default:     wr_stb         = '0;
         endcase
      end
   end

endmodule

// File: rtl/ring_cfg_store.sv
module ring_cfg_store
   import ring_ptr_pkg::*;
#(
   parameter int unsigned CRED_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_strobe_t        wr_stb,
   input  logic [31:0]       wdata,
   output logic [63:0]       base_addr,
   output logic [CRED_W-1:0] credits
);

   if (CRED_W < 1 || CRED_W > 32) begin : g_cred_err
      initial $fatal(1, "CRED_W must be 1..32");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr <= '0;
         credits   <= '0;
      end else begin
         if (wr_stb.base_lo) base_addr[31:0]  <= wdata;
         if (wr_stb.base_hi) base_addr[63:32] <= wdata;
         if (wr_stb.cred)    credits          <= wdata[CRED_W-1:0];
      end
   end

endmodule

// File: rtl/ring_ptr_core.sv
module ring_ptr_core
   import ring_ptr_pkg::*;
#(
   parameter int unsigned MAX_LOG2 = 16,
   localparam int unsigned IDX_W   = MAX_LOG2,
   localparam int unsigned SIZE_W  = MAX_LOG2 + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_strobe_t        wr_stb,
   input  logic [31:0]       wdata,
   input  logic              cmpl_strobe,
   output logic [SIZE_W-1:0] size_q,
   output logic [IDX_W-1:0]  head_q,
   output logic [IDX_W-1:0]  tail_q,
   output logic [IDX_W-1:0]  mask,
   output logic              fault_q
);

   localparam logic [31:0] MAX_SIZE = 32'd1 << MAX_LOG2;
   localparam logic [31:0] MIN_SIZE = 32'd2;

   if (MAX_LOG2 < 1 || MAX_LOG2 > 16) begin : g_log2_err
      initial $fatal(1, "MAX_LOG2 must be 1..16");
   end

   logic             size_legal;
   logic             clear_idx;
   logic             in_range;
   logic [IDX_W-1:0] wr_val;
   logic [IDX_W-1:0] move_dist;
   logic [IDX_W-1:0] free_slots;
   logic             head_ok;
   logic             tail_step;

   always_comb begin
      size_legal = (wdata >= MIN_SIZE) && (wdata <= MAX_SIZE) &&
                   ($countones(wdata) == 1);
      clear_idx  = wr_stb.base_lo | wr_stb.base_hi | wr_stb.size |
                   (wr_stb.ctrl & wdata[CTRL_RESET_BIT]);
      mask       = IDX_W'(size_q - SIZE_W'(1));
      in_range   = wdata < 32'(size_q);
      wr_val     = wdata[IDX_W-1:0];
      move_dist  = (wr_val - head_q) & mask;
      free_slots = (tail_q - head_q - IDX_W'(1)) & mask;
      head_ok    = wr_stb.head && in_range && (move_dist <= free_slots);
      tail_step  = cmpl_strobe && (tail_q != head_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q  <= SIZE_W'(MIN_SIZE);
         head_q  <= '0;
         tail_q  <= '0;
         fault_q <= 1'b0;
      end else begin
         if (wr_stb.size && size_legal) size_q <= wdata[SIZE_W-1:0];
         if (clear_idx) begin
            head_q  <= '0;
            tail_q  <= '0;
            fault_q <= 1'b0;
         end else begin
            if (head_ok)                  head_q  <= wr_val;
            if (wr_stb.head && !in_range) fault_q <= 1'b1;
            if (tail_step)                tail_q  <= (tail_q + IDX_W'(1)) & mask;
         end
      end
   end

endmodule

// File: rtl/ring_status.sv
module ring_status #(
   parameter int unsigned IDX_W = 16
) (
   input  logic [IDX_W-1:0] head_q,
   input  logic [IDX_W-1:0] tail_q,
   input  logic [IDX_W-1:0] mask,
   output logic             empty,
   output logic             full,
   output logic [IDX_W-1:0] avail
);

   always_comb begin
      empty = (head_q == tail_q);
      full  = (((head_q + IDX_W'(1)) & mask) == tail_q);
      avail = (head_q - tail_q) & mask;
   end

endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
   import ring_ptr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned WIN_BASE = 'h1000,
   parameter int unsigned RING_IDX = 2,
   parameter int unsigned MAX_LOG2 = 16,
   parameter int unsigned CRED_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic                cmpl_strobe,
   output logic [63:0]         base_addr,
   output logic [MAX_LOG2:0]   ring_size,
   output logic [MAX_LOG2-1:0] head_idx,
   output logic [MAX_LOG2-1:0] tail_idx,
   output logic                ring_empty,
   output logic                ring_full,
   output logic [MAX_LOG2-1:0] work_avail,
   output logic                fault
);

   localparam int unsigned IDX_W = MAX_LOG2;

   logic              hit;
   reg_sel_e          sel;
   wr_strobe_t        wr_stb;
   logic [CRED_W-1:0] credits;
   logic [IDX_W-1:0]  mask;

   ring_reg_decode #(
      .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .RING_IDX(RING_IDX)
   ) i_decode (
      .reg_wr(reg_wr), .reg_addr(reg_addr),
      .hit(hit), .sel(sel), .wr_stb(wr_stb)
   );

   ring_cfg_store #(.CRED_W(CRED_W)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wdata(reg_wdata),
      .base_addr(base_addr), .credits(credits)
   );

   ring_ptr_core #(.MAX_LOG2(MAX_LOG2)) i_core (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wdata(reg_wdata),
      .cmpl_strobe(cmpl_strobe), .size_q(ring_size), .head_q(head_idx),
      .tail_q(tail_idx), .mask(mask), .fault_q(fault)
   );

   ring_status #(.IDX_W(IDX_W)) i_status (
      .head_q(head_idx), .tail_q(tail_idx), .mask(mask),
      .empty(ring_empty), .full(ring_full), .avail(work_avail)
   );

   always_comb begin
      reg_rdata = '0;
      if (hit) begin
         unique case (sel)
            SEL_BASE_LO: reg_rdata = base_addr[31:0];
            SEL_BASE_HI: reg_rdata = base_addr[63:32];
            SEL_SIZE:    reg_rdata = 32'(ring_size);
            SEL_HEAD:    reg_rdata = 32'(head_idx);
            SEL_TAIL:    reg_rdata = 32'(tail_idx);
            SEL_CRED:    reg_rdata = 32'(credits);
            default:     reg_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/ring_ptr_chk.sv
module ring_ptr_chk #(
   parameter int unsigned IDX_W  = 16,
   parameter int unsigned SIZE_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              cmpl_strobe,
   input logic [SIZE_W-1:0] ring_size,
   input logic [IDX_W-1:0]  head_idx,
   input logic [IDX_W-1:0]  tail_idx,
   input logic              ring_empty,
   input logic              ring_full,
   input logic              fault
);

   logic [IDX_W-1:0] chk_mask;
   logic [IDX_W-1:0] chk_next_tail;

   always_comb begin
      chk_mask      = IDX_W'(ring_size - SIZE_W'(1));
      chk_next_tail = (tail_idx + IDX_W'(1)) & chk_mask;
   end

   // R3
   size_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(ring_size) && (ring_size >= SIZE_W'(2)));

   // R7
   head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      SIZE_W'(head_idx) < ring_size);

   // R9
   tail_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      SIZE_W'(tail_idx) < ring_size);

   // R9
   tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_idx != $past(tail_idx)) |->
         ((tail_idx == '0) || (tail_idx == $past(chk_next_tail))));

   // R9
   tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && (head_idx == tail_idx)) |=> $stable(tail_idx));

   // R9
   tail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && !cmpl_strobe) |=> $stable(tail_idx));

   // R10
   empty_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ring_empty && ring_full));

   // R8
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !reg_wr) |=> fault);

endmodule

bind ring_ptr_mgr ring_ptr_chk #(
   .IDX_W(MAX_LOG2), .SIZE_W(MAX_LOG2 + 1)
) i_ring_ptr_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .cmpl_strobe(cmpl_strobe),
   .ring_size(ring_size), .head_idx(head_idx), .tail_idx(tail_idx),
   .ring_empty(ring_empty), .ring_full(ring_full), .fault(fault)
);

// File: tb/test_ring_ptr_mgr.sv
module test_ring_ptr_mgr;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] WIN = 16'h1040;   // 0x1000 + 32*2

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cmpl_strobe = 1'b0;
   logic [63:0] base_addr;
   logic [16:0] ring_size;
   logic [15:0] head_idx, tail_idx, work_avail;
   logic        ring_empty, ring_full, fault;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ring_ptr_mgr i_ring_ptr_mgr (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmpl_strobe(cmpl_strobe),
      .base_addr(base_addr), .ring_size(ring_size), .head_idx(head_idx),
      .tail_idx(tail_idx), .ring_empty(ring_empty), .ring_full(ring_full),
      .work_avail(work_avail), .fault(fault)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic strobe(input int n);
      @(negedge clk);
      cmpl_strobe = 1'b1;
      repeat (n) @(negedge clk);
      cmpl_strobe = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1", "head", 64'(head_idx), 0);
      chk("R1", "tail", 64'(tail_idx), 0);
      chk("R1", "size", 64'(ring_size), 2);
      chk("R1", "base", base_addr, 0);
      chk("R1", "fault", 64'(fault), 0);
      chk("R1", "empty", 64'(ring_empty), 1);
      chk("R1", "full", 64'(ring_full), 0);
      rd(WIN + 16'h18, d);
      chk("R1", "credits", 64'(d), 0);
   endtask

   task automatic t_size;
      wr(WIN + 16'h08, 32'd65536);
      chk("R3", "size max accepted", 64'(ring_size), 65536);
      wr(WIN + 16'h08, 32'd8);
      chk("R3", "size 8", 64'(ring_size), 8);
      wr(WIN + 16'h08, 32'd6);
      chk("R3", "size 6 rejected", 64'(ring_size), 8);
      wr(WIN + 16'h08, 32'd1);
      chk("R3", "size 1 rejected", 64'(ring_size), 8);
      wr(WIN + 16'h08, 32'h20000);
      chk("R3", "size too big rejected", 64'(ring_size), 8);
   endtask

   task automatic t_progress;
      wr(WIN + 16'h0C, 32'd5);
      chk("R7", "head 5", 64'(head_idx), 5);
      chk("R10", "avail 5", 64'(work_avail), 5);
      chk("R10", "not empty", 64'(ring_empty), 0);
      strobe(5);
      chk("R9", "tail after 5 strobes", 64'(tail_idx), 5);
      chk("R10", "empty", 64'(ring_empty), 1);
      strobe(3);
      chk("R9", "tail held while empty", 64'(tail_idx), 5);
   endtask

   task automatic t_wrap_full;
      wr(WIN + 16'h0C, 32'd4);
      chk("R7", "head wraps to 4", 64'(head_idx), 4);
      chk("R10", "full", 64'(ring_full), 1);
      chk("R10", "avail 7", 64'(work_avail), 7);
      wr(WIN + 16'h0C, 32'd5);
      chk("R7", "overtake refused", 64'(head_idx), 4);
      chk("R7", "no fault on overtake", 64'(fault), 0);
      wr(WIN + 16'h0C, 32'd9);
      chk("R7", "out of range head unchanged", 64'(head_idx), 4);
      chk("R8", "fault set", 64'(fault), 1);
      strobe(3);
      chk("R9", "tail wraps to 0", 64'(tail_idx), 0);
      chk("R10", "avail 4", 64'(work_avail), 4);
      chk("R8", "fault sticky", 64'(fault), 1);
   endtask

   task automatic t_ctrl;
      logic [31:0] d;
      wr(WIN + 16'h14, 32'hFFFF_FFFE);
      chk("R5", "bit0 clear keeps head", 64'(head_idx), 4);
      chk("R5", "bit0 clear keeps fault", 64'(fault), 1);
      wr(WIN + 16'h14, 32'd1);
      chk("R5", "reset head", 64'(head_idx), 0);
      chk("R5", "reset tail", 64'(tail_idx), 0);
      chk("R5", "reset fault", 64'(fault), 0);
      chk("R5", "size kept", 64'(ring_size), 8);
      rd(WIN + 16'h14, d);
      chk("R2", "control reads 0", 64'(d), 0);
   endtask

   task automatic t_tail_ro;
      logic [31:0] d;
      wr(WIN + 16'h0C, 32'd3);
      wr(WIN + 16'h10, 32'd7);
      chk("R6", "tail unchanged", 64'(tail_idx), 0);
      rd(WIN + 16'h10, d);
      chk("R6", "tail read", 64'(d), 0);
      rd(WIN + 16'h0C, d);
      chk("R2", "head read", 64'(d), 3);
   endtask

   task automatic t_base;
      logic [31:0] d;
      wr(WIN + 16'h00, 32'hABCD_0008);
      chk("R4", "base write clears head", 64'(head_idx), 0);
      wr(WIN + 16'h0C, 32'd2);
      strobe(1);
      chk("R9", "tail 1", 64'(tail_idx), 1);
      wr(WIN + 16'h04, 32'h0000_1234);
      chk("R4", "base hi clears tail", 64'(tail_idx), 0);
      chk("R4", "base hi clears head", 64'(head_idx), 0);
      chk("R2", "base out", base_addr, 64'h0000_1234_ABCD_0008);
      rd(WIN + 16'h04, d);
      chk("R2", "base hi read", 64'(d), 64'h1234);
      wr(WIN + 16'h0C, 32'd6);
      wr(WIN + 16'h08, 32'd3);
      chk("R4", "rejected size write still clears", 64'(head_idx), 0);
      chk("R3", "size kept at 8", 64'(ring_size), 8);
   endtask

   task automatic t_cred_window;
      logic [31:0] d;
      wr(WIN + 16'h18, 32'hC0DE_0055);
      rd(WIN + 16'h18, d);
      chk("R11", "credits readback", 64'(d), 64'hC0DE_0055);
      wr(16'h1068, 32'd4);
      chk("R2", "other window size ignored", 64'(ring_size), 8);
      rd(16'h1068, d);
      chk("R2", "other window reads 0", 64'(d), 0);
      rd(WIN + 16'h1C, d);
      chk("R2", "spare reads 0", 64'(d), 0);
      rd(WIN + 16'h09, d);
      chk("R2", "unaligned reads 0", 64'(d), 0);
      rd(WIN + 16'h08, d);
      chk("R2", "size read", 64'(d), 8);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_size();
      t_progress();
      t_wrap_full();
      t_ctrl();
      t_tail_ro();
      t_base();
      t_cred_window();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule